// File: doc/BRIEF.md
# Memory access wait-state inserter

This block decides when the main processor must lose one extra clock on a memory access. The processor reports each access with a one-cycle strobe. The block counts these strobes against a wait factor and raises a one-cycle stall request once the count reaches that factor. The wait factor follows from four level inputs:

- a slow-speed select;
- a memory-mapper enable;
- a window-mapping enable;
- a fast-mapping select.

The block also keeps a phase bit that flips on every stall. A neighbouring block may use this bit to alternate its own handling of successive waits.

The four mode inputs are watched continuously. Any change in them restarts the count, so that stalls under the new setting are spaced from the first access after the change. The four factor values are parameters, and elaboration checks that each one is usable with the counter width.

Top module: `wsi_wait_inserter`

## Requirements
- R1: During reset and on the first sampled cycle after it, `stall_req` is 0 and `wait_phase` is 0. The access count starts at zero.
- R2: While `slow_sel` is 1, no stall is ever requested, whatever the other mode inputs and the accesses.
- R3: With `slow_sel`, `mapper_en` and `window_en` all 0 and `fast_sel` 0, the wait factor is 3 and a stall follows every third access.
- R4: With `slow_sel`, `mapper_en` and `window_en` all 0 and `fast_sel` 1, the wait factor is 2 and a stall follows every second access.
- R5: With `slow_sel` 0, at least one of `mapper_en` or `window_en` at 1, and `fast_sel` 0, the wait factor is 3.
- R6: With `slow_sel` 0, at least one of `mapper_en` or `window_en` at 1, and `fast_sel` 1, the wait factor is 0 and no stall is produced.
- R7: `stall_req` is high for exactly one cycle. It is high only in the cycle right after a clock edge at which `acc_stb` was 1 and the count reached the factor. The count then returns to zero.
- R8: `wait_phase` inverts in the same cycle that `stall_req` rises, and holds its value in every other cycle.
- R9: A change of any mode input, sampled at a clock edge, clears the access count. An access at that same edge counts as the first access under the new setting.
- R10: Clock edges without `acc_stb` leave the count unchanged, so idle gaps between accesses do not shift the stall spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_sel | input | 1 | Slow processor speed selected; disables all waits |
| mapper_en | input | 1 | Memory mapper enabled |
| window_en | input | 1 | Window mapping enabled |
| fast_sel | input | 1 | Fast mapping mode selected |
| acc_stb | input | 1 | One memory access at this clock edge |
| stall_req | output | 1 | One-cycle request for one extra processor clock |
| wait_phase | output | 1 | Bit that flips on every stall |

## Verification
The bench looks for one collision in particular: a mode change sampled at the same edge as an access. In that case the count clear and the increment land in one cycle. The bench provokes it by entering every one of the sixteen mode combinations with an access on the changing edge, often while a partial count is pending. It judges the result by whether the next stall arrives exactly factor-minus-one further accesses later, with no leftover count from the old setting. A second collision is a stall on the access right before a mode change. It is judged by `wait_phase` flipping once and the new setting starting from zero.

// File: rtl/wsi_pkg.sv
package wsi_pkg;

   // Mode inputs sampled together; a change in any field restarts the count
   typedef struct packed {
      logic slow;
      logic mapper;
      logic window;
      logic fast;
   } wsi_mode_t;

   localparam int unsigned MODE_W = $bits(wsi_mode_t);

   // A factor of 1 would allow back-to-back stalls; 0 means "never stall"
   function automatic bit factor_ok(input int unsigned f, input int unsigned cnt_w);
      return (f == 0) || ((f >= 2) && (f < (1 << cnt_w)));
   endfunction

endpackage

// File: rtl/wsi_factor_sel.sv
module wsi_factor_sel
   import wsi_pkg::*;
#(
   parameter int unsigned CNT_W         = 4,
   parameter int unsigned FAC_PLAIN     = 3,
   parameter int unsigned FAC_PLAIN_FST = 2,
   parameter int unsigned FAC_MAP       = 3,
   parameter int unsigned FAC_MAP_FST   = 0
) (
   input  wsi_mode_t        mode_i,
   output logic [CNT_W-1:0] factor_o,
   output logic             active_o
);

   localparam logic [CNT_W-1:0] F_PLAIN     = CNT_W'(FAC_PLAIN);
   localparam logic [CNT_W-1:0] F_PLAIN_FST = CNT_W'(FAC_PLAIN_FST);
   localparam logic [CNT_W-1:0] F_MAP       = CNT_W'(FAC_MAP);
   localparam logic [CNT_W-1:0] F_MAP_FST   = CNT_W'(FAC_MAP_FST);

   logic mapped;
   logic [CNT_W-1:0] fac;

   assign mapped = mode_i.mapper | mode_i.window;

   always_comb begin
      if (mode_i.slow) begin
         fac = '0;
      end else if (mapped) begin
         fac = mode_i.fast ? F_MAP_FST : F_MAP;
      end else begin
         fac = mode_i.fast ? F_PLAIN_FST : F_PLAIN;
      end
   end

   assign factor_o = fac;
   assign active_o = (fac != '0);

endmodule

// File: rtl/wsi_mode_track.sv
module wsi_mode_track
   import wsi_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  wsi_mode_t mode_i,
   output logic      change_o
);

   logic [MODE_W-1:0] cur;
   logic [MODE_W-1:0] prev_q;
   logic [MODE_W-1:0] bit_chg;

   assign cur = mode_i;

   // Per-field edge detection
   for (genvar i = 0; i < MODE_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
         end else begin
            prev_q[i] <= cur[i];
         end
      end
      assign bit_chg[i] = cur[i] ^ prev_q[i];
   end

   assign change_o = |bit_chg;

endmodule

// File: rtl/wsi_access_cnt.sv
module wsi_access_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_i,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] factor_i,
   input  logic             active_i,
   output logic             stall_o,
   output logic             phase_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   nxt;
   logic             hit;
   logic             stall_q;
   logic             phase_q;

   // A mode change drops the old count before this edge's access is added
   assign base = clear_i ? '0 : cnt_q;
   assign nxt  = {1'b0, base} + {{CNT_W{1'b0}}, 1'b1};
   assign hit  = acc_i && active_i && (nxt >= {1'b0, factor_i});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         stall_q <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         stall_q <= hit;
         if (hit) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else if (acc_i && active_i) begin
            cnt_q <= nxt[CNT_W-1:0];
         end else if (acc_i) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= base;
         end
      end
   end

   assign stall_o = stall_q;
   assign phase_o = phase_q;

endmodule

// File: rtl/wsi_wait_inserter.sv
module wsi_wait_inserter
   import wsi_pkg::*;
#(
   parameter int unsigned CNT_W         = 4,
   parameter int unsigned FAC_PLAIN     = 3,
   parameter int unsigned FAC_PLAIN_FST = 2,
   parameter int unsigned FAC_MAP       = 3,
   parameter int unsigned FAC_MAP_FST   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_sel,
   input  logic mapper_en,
   input  logic window_en,
   input  logic fast_sel,
   input  logic acc_stb,
   output logic stall_req,
   output logic wait_phase
);

   if (CNT_W < 2) begin : g_bad_width
      $error("wsi_wait_inserter: CNT_W must be at least 2");
   end
   if (!factor_ok(FAC_PLAIN, CNT_W) || !factor_ok(FAC_PLAIN_FST, CNT_W) ||
       !factor_ok(FAC_MAP, CNT_W)   || !factor_ok(FAC_MAP_FST, CNT_W)) begin : g_bad_factor
      $error("wsi_wait_inserter: each factor must be 0 or in 2..2**CNT_W-1");
   end

   wsi_mode_t        mode;
   logic             mode_chg;
   logic [CNT_W-1:0] factor;
   logic             active;

   assign mode = '{slow: slow_sel, mapper: mapper_en, window: window_en, fast: fast_sel};

   wsi_mode_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .change_o (mode_chg)
   );

   wsi_factor_sel #(
      .CNT_W         (CNT_W),
      .FAC_PLAIN     (FAC_PLAIN),
      .FAC_PLAIN_FST (FAC_PLAIN_FST),
      .FAC_MAP       (FAC_MAP),
      .FAC_MAP_FST   (FAC_MAP_FST)
   ) u_sel (
      .mode_i   (mode),
      .factor_o (factor),
      .active_o (active)
   );

   wsi_access_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_i    (acc_stb),
      .clear_i  (mode_chg),
      .factor_i (factor),
      .active_i (active),
      .stall_o  (stall_req),
      .phase_o  (wait_phase)
   );

endmodule

// File: rtl/wsi_wait_inserter_chk.sv
module wsi_wait_inserter_chk (
   input logic clk,
   input logic rst_n,
   input logic slow_sel,
   input logic mapper_en,
   input logic window_en,
   input logic fast_sel,
   input logic acc_stb,
   input logic stall_req,
   input logic wait_phase
);

   p_slow_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |-> !$past(slow_sel));

   p_mapped_fast_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |-> !($past(fast_sel) && !$past(slow_sel) &&
                      ($past(mapper_en) || $past(window_en))));

   p_needs_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |-> $past(acc_stb));

   p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |=> !stall_req);

   p_phase_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |-> (wait_phase != $past(wait_phase)));

   p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_req |-> $stable(wait_phase));

   p_reset_idle_r1: assert property (@(posedge clk)
      !$past(rst_n) |-> (!stall_req && !wait_phase));

endmodule

bind wsi_wait_inserter wsi_wait_inserter_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .slow_sel   (slow_sel),
   .mapper_en  (mapper_en),
   .window_en  (window_en),
   .fast_sel   (fast_sel),
   .acc_stb    (acc_stb),
   .stall_req  (stall_req),
   .wait_phase (wait_phase)
);

// File: tb/wsi_wait_inserter_tb_top.sv
module wsi_wait_inserter_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_sel = 1'b0, mapper_en = 1'b0, window_en = 1'b0, fast_sel = 1'b0;
   logic acc_stb = 1'b0;
   logic stall_req, wait_phase;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model state
   logic [3:0] m_prev = 4'b0;
   int         m_cnt = 0;
   logic       m_stall = 1'b0;
   logic       m_phase = 1'b0;

   always #2.5 clk = ~clk;

   wsi_wait_inserter dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_sel   (slow_sel),
      .mapper_en  (mapper_en),
      .window_en  (window_en),
      .fast_sel   (fast_sel),
      .acc_stb    (acc_stb),
      .stall_req  (stall_req),
      .wait_phase (wait_phase)
   );

   function automatic int factor_of(input logic [3:0] f);
      // f = {slow, mapper, window, fast}
      if (f[3]) return 0;
      if (f[2] | f[1]) return f[0] ? 0 : 3;
      return f[0] ? 2 : 3;
   endfunction

   function automatic string tag_of(input logic [3:0] f);
      if (f[3]) return "R2";
      if (f[2] | f[1]) return f[0] ? "R6" : "R5";
      return f[0] ? "R4" : "R3";
   endfunction

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // Called at a negedge: drive, advance the model, check at the next negedge
   task automatic step(input logic [3:0] f, input logic a, input string req);
      logic chg;
      int   base;
      int   fac;
      {slow_sel, mapper_en, window_en, fast_sel} = f;
      acc_stb = a;
      chg    = (f != m_prev);
      m_prev = f;
      base   = chg ? 0 : m_cnt;
      fac    = factor_of(f);
      m_stall = 1'b0;
      if (a) begin
         if (fac == 0) m_cnt = 0;
         else if (base + 1 >= fac) begin
            m_stall = 1'b1;
            m_phase = ~m_phase;
            m_cnt = 0;
         end else m_cnt = base + 1;
      end else m_cnt = base;
      @(posedge clk);
      @(negedge clk);
      check_bit(req, "stall_req", stall_req, m_stall);
      check_bit("R8", "wait_phase", wait_phase, m_phase);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check_bit("R1", "stall_req in reset", stall_req, 1'b0);
      check_bit("R1", "wait_phase in reset", wait_phase, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", "stall_req after reset", stall_req, 1'b0);
      check_bit("R1", "wait_phase after reset", wait_phase, 1'b0);

      // R7: no access, no stall
      for (int i = 0; i < 4; i++) step(4'b0000, 1'b0, "R7");

      // Sweep every mode combination; the entering access collides with the change (R9)
      for (int pass = 0; pass < 2; pass++) begin
         for (int code = 0; code < 16; code++) begin
            logic [3:0] f;
            f = 4'(pass == 0 ? code : 15 - code);
            step(f, 1'b1, "R9");
            for (int k = 0; k < 10; k++) begin
               if (k % 3 == 2) step(f, 1'b0, "R10");
               else step(f, 1'b1, tag_of(f));
            end
         end
      end

      // R9: partial count discarded by two mode toggles without access
      step(4'b0000, 1'b1, "R3");
      step(4'b0000, 1'b1, "R3");
      step(4'b0010, 1'b0, "R9");
      step(4'b0000, 1'b0, "R9");
      step(4'b0000, 1'b1, "R9");
      step(4'b0000, 1'b1, "R9");
      step(4'b0000, 1'b1, "R9");

      // R10: long idle gap keeps the count
      step(4'b0001, 1'b1, "R4");
      for (int i = 0; i < 6; i++) step(4'b0001, 1'b0, "R10");
      step(4'b0001, 1'b1, "R10");

      // R7: back-to-back accesses at factor 2 never give adjacent stalls
      for (int i = 0; i < 8; i++) step(4'b0001, 1'b1, "R7");

      // R2: slow with fast-mapping flags set, long burst
      for (int i = 0; i < 12; i++) step(4'b1001, 1'b1, "R2");
      // R6: window only, fast
      for (int i = 0; i < 8; i++) step(4'b0011, 1'b1, "R6");
      // R5: mapper only
      for (int i = 0; i < 7; i++) step(4'b0100, 1'b1, "R5");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule